// File: doc/BRIEF.md
# Serial Flash Register-Command Decoder

This block is the receiving front end of a serial flash device. It watches chip select, serial clock and up to four data lines, all sampled by the device's system clock. It decodes three register commands: set the write enable latch, write a sector's lock bits, and clear the error flags. Frames arrive on one, two or four lanes, as chosen by a mode input. The block holds a volatile two-bit lock entry for every sector, the write enable latch, and three error flags. The device's erase and program engine sets those flags.

A command takes effect only when chip select returns high and the frame is complete. The lock write has a fixed length that depends on the address width and the lane count. The decoder works out where the address ends and the data byte begins. It rejects a lock frame that is one clock short or one clock long. The error-flag clear needs only its command byte, and any number of further clocks may follow it. Lock state changes in the cycle after the commit, with no busy period.

Top module: `spi_reg_cmd_decoder`

## Requirements
- R1: After reset, every lock bit, the write enable latch and the three error flags read zero.
- R2: Opcode 0x06, shifted MSB first and followed by chip select rising after exactly the clocks of one command byte, sets `wel`.
- R3: Opcode 0xE5 with `wel` set takes ADDR_BITS address bits and then one data byte, all MSB first. It commits on chip select rising after exactly (16+ADDR_BITS)/lanes clocks. The top log2(NUM_SECTORS) address bits select the sector, and data bits [1:0] land on `lock_bits[2s+1:2s]` of sector s.
- R4: `mode` 0 uses `dq[0]` alone, mode 1 uses `dq[1:0]` with `dq[1]` carrying the earlier bit, and mode 2 uses `dq[3:0]` with `dq[3]` first. The data byte occupies the last 8/lanes clocks of the frame, after 8/lanes command clocks and ADDR_BITS/lanes address clocks.
- R5: A committed lock write clears `wel` and leaves `flag_status[2:0]` unchanged.
- R6: A lock write received while `wel` is clear changes no lock bit.
- R7: A lock frame with one clock too few or one clock too many is discarded, and `wel` stays set.
- R8: Lock writes are accepted while `erase_suspend` is high, and `flag_status[3]` follows `erase_suspend`.
- R9: Opcode 0x50 clears `flag_status[2:0]` on chip select rising after at least one full command byte, whatever the number of extra clocks. A frame cut off before the byte completes has no effect.
- R10: A high bit of `err_set` sets the matching flag (bit 2 erase, bit 1 program, bit 0 protection). A set in the same cycle as a clear prevails.
- R11: Any other opcode changes neither `wel` nor any lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial input |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| dq | input | 4 | Serial data lanes |
| mode | input | 2 | Lane mode: 0 one lane, 1 two lanes, 2 four lanes |
| erase_suspend | input | 1 | High while an erase is suspended |
| err_set | input | 3 | Error reports from the execution engine: erase, program, protection |
| wel | output | 1 | Write enable latch |
| flag_status | output | 4 | {suspend, erase error, program error, protection error} |
| lock_bits | output | 2*NUM_SECTORS | Two lock bits per sector, sector s at [2s+1:2s] |

## Verification
Several properties are checked on every cycle:
- at most one command commits at a time;
- a lock write needs the latch and clears it;
- lock bits move only on a lock commit;
- a clear zeroes the flags;
- an error report survives a simultaneous clear;
- a lock commit leaves the flags alone.

The bench scenarios cover what depends on framing. These are lane ordering in each mode, the exact frame length and its off-by-one rejections, sector selection from the upper address bits, and acceptance during an erase suspend. They also cover the partial command byte that must not clear anything.

// File: rtl/spi_rc_pkg.sv
`timescale 1ns/1ps
package spi_rc_pkg;

    typedef enum logic [1:0] {
        LANES_X1 = 2'd0,
        LANES_X2 = 2'd1,
        LANES_X4 = 2'd2
    } lane_mode_e;

    localparam logic [7:0] OP_SET_WEL   = 8'h06;
    localparam logic [7:0] OP_LOCK_WR   = 8'hE5;
    localparam logic [7:0] OP_FLAG_CLR  = 8'h50;

endpackage

// File: rtl/spi_rc_sampler.sv
`timescale 1ns/1ps
module spi_rc_sampler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] dq,
    output logic       sck_rise,
    output logic       cs_rise,
    output logic       cs_fall,
    output logic [3:0] dq_s
);

    typedef struct packed {
        logic       cs;
        logic       cs_prev;
        logic       sck;
        logic       sck_prev;
        logic [3:0] dq;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.cs       = cs_n;
        smp_d.cs_prev  = smp_q.cs;
        smp_d.sck      = sck;
        smp_d.sck_prev = smp_q.sck;
        smp_d.dq       = dq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{cs: 1'b1, cs_prev: 1'b1, sck: 1'b0, sck_prev: 1'b0, dq: 4'h0};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign sck_rise = smp_q.sck & ~smp_q.sck_prev & ~smp_q.cs;
    assign cs_rise  = smp_q.cs & ~smp_q.cs_prev;
    assign cs_fall  = ~smp_q.cs & smp_q.cs_prev;
    assign dq_s     = smp_q.dq;

endmodule

// File: rtl/spi_rc_frame.sv
`timescale 1ns/1ps
module spi_rc_frame
    import spi_rc_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int SEC_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_rise,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic [3:0]       dq_s,
    input  logic [1:0]       mode,
    input  logic             wel,
    output logic             wren_go,
    output logic             wlock_go,
    output logic             clr_go,
    output logic [SEC_W-1:0] go_sector,
    output logic [1:0]       go_lock
);

    localparam int SHW   = ADDR_BITS + 8;
    localparam int CNT_W = $clog2(ADDR_BITS + 18);

    localparam logic [CNT_W-1:0] CMD_X1  = CNT_W'(8);
    localparam logic [CNT_W-1:0] CMD_X2  = CNT_W'(4);
    localparam logic [CNT_W-1:0] CMD_X4  = CNT_W'(2);
    // data byte starts after command and address clocks; frame ends 8/lanes later
    localparam logic [CNT_W-1:0] FULL_X1 = CNT_W'(8 + ADDR_BITS + 8);
    localparam logic [CNT_W-1:0] FULL_X2 = CNT_W'((8 + ADDR_BITS) / 2 + 4);
    localparam logic [CNT_W-1:0] FULL_X4 = CNT_W'((8 + ADDR_BITS) / 4 + 2);

    typedef struct packed {
        lane_mode_e        lanes;
        logic [CNT_W-1:0]  cnt;
        logic [SHW-1:0]    shreg;
        logic [7:0]        op;
        logic              op_valid;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [CNT_W-1:0] cmd_clk, full_clk;
    logic [SHW-1:0]   shifted;

    always_comb begin
        case (frm_q.lanes)
            LANES_X2: begin
                cmd_clk  = CMD_X2;
                full_clk = FULL_X2;
                shifted  = {frm_q.shreg[SHW-3:0], dq_s[1:0]};
            end
            LANES_X4: begin
                cmd_clk  = CMD_X4;
                full_clk = FULL_X4;
                shifted  = {frm_q.shreg[SHW-5:0], dq_s};
            end
            default: begin
                cmd_clk  = CMD_X1;
                full_clk = FULL_X1;
                shifted  = {frm_q.shreg[SHW-2:0], dq_s[0]};
            end
        endcase

        frm_d = frm_q;
        if (cs_fall) begin
            frm_d.cnt      = '0;
            frm_d.op_valid = 1'b0;
            case (mode)
                2'd1:    frm_d.lanes = LANES_X2;
                2'd2:    frm_d.lanes = LANES_X4;
                default: frm_d.lanes = LANES_X1;
            endcase
        end else if (sck_rise) begin
            frm_d.shreg = shifted;
            if (frm_q.cnt != '1) begin
                frm_d.cnt = frm_q.cnt + 1'b1;
            end
            if (frm_q.cnt + 1'b1 == cmd_clk) begin
                frm_d.op       = shifted[7:0];
                frm_d.op_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{lanes: LANES_X1, cnt: '0, shreg: '0, op: 8'h00, op_valid: 1'b0};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign wren_go   = cs_rise & frm_q.op_valid & (frm_q.op == OP_SET_WEL) & (frm_q.cnt == cmd_clk);
    assign wlock_go  = cs_rise & frm_q.op_valid & (frm_q.op == OP_LOCK_WR) & (frm_q.cnt == full_clk) & wel;
    assign clr_go    = cs_rise & frm_q.op_valid & (frm_q.op == OP_FLAG_CLR);
    assign go_sector = frm_q.shreg[SHW-1 -: SEC_W];
    assign go_lock   = frm_q.shreg[1:0];

    // R2 R3 R9: a frame commits at most one command
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_go, wlock_go, clr_go}));

    // R9: nothing commits before the command byte is complete
    a_r9_needs_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frm_q.cnt < cmd_clk) |-> !(wren_go || wlock_go || clr_go));

    // R11: commits come only at chip-select rise
    a_r11_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |-> !(wren_go || wlock_go || clr_go));

endmodule

// File: rtl/spi_rc_regs.sv
`timescale 1ns/1ps
module spi_rc_regs #(
    parameter int NUM_SECTORS = 16,
    parameter int SEC_W       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wren_go,
    input  logic                     wlock_go,
    input  logic                     clr_go,
    input  logic [SEC_W-1:0]         go_sector,
    input  logic [1:0]               go_lock,
    input  logic [2:0]               err_set,
    output logic                     wel,
    output logic [2:0]               err,
    output logic [2*NUM_SECTORS-1:0] lock_bits
);

    typedef struct packed {
        logic                         wel;
        logic [2:0]                   err;
        logic [NUM_SECTORS-1:0][1:0]  lock;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wren_go) begin
            reg_d.wel = 1'b1;
        end
        if (wlock_go) begin
            reg_d.wel = 1'b0;
            reg_d.lock[go_sector] = go_lock;
        end
        if (clr_go) begin
            reg_d.err = 3'b000;
        end
        reg_d.err = reg_d.err | err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign wel = reg_q.wel;
    assign err = reg_q.err;

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock_out
        assign lock_bits[2*s +: 2] = reg_q.lock[s];
    end

    a_r2_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
        wren_go |=> reg_q.wel);

    a_r5_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wlock_go |=> !reg_q.wel);

    a_r6_lock_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        wlock_go |-> reg_q.wel);

    a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wlock_go |=> $stable(reg_q.lock));

    a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_go && err_set == 3'b000) |=> reg_q.err == 3'b000);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != 3'b000) |=> ((reg_q.err & $past(err_set)) == $past(err_set)));

    a_r5_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wlock_go && err_set == 3'b000) |=> $stable(reg_q.err));

endmodule

// File: rtl/spi_reg_cmd_decoder.sv
`timescale 1ns/1ps
module spi_reg_cmd_decoder #(
    parameter int ADDR_BITS   = 24,
    parameter int NUM_SECTORS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sck,
    input  logic [3:0]               dq,
    input  logic [1:0]               mode,
    input  logic                     erase_suspend,
    input  logic [2:0]               err_set,
    output logic                     wel,
    output logic [3:0]               flag_status,
    output logic [2*NUM_SECTORS-1:0] lock_bits
);

    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

    logic             sck_rise, cs_rise, cs_fall;
    logic [3:0]       dq_s;
    logic             wren_go, wlock_go, clr_go;
    logic [SEC_W-1:0] go_sector;
    logic [1:0]       go_lock;
    logic [2:0]       err;

    spi_rc_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .dq       (dq),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .dq_s     (dq_s)
    );

    spi_rc_frame #(
        .ADDR_BITS (ADDR_BITS),
        .SEC_W     (SEC_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .dq_s      (dq_s),
        .mode      (mode),
        .wel       (wel),
        .wren_go   (wren_go),
        .wlock_go  (wlock_go),
        .clr_go    (clr_go),
        .go_sector (go_sector),
        .go_lock   (go_lock)
    );

    spi_rc_regs #(
        .NUM_SECTORS (NUM_SECTORS),
        .SEC_W       (SEC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wren_go   (wren_go),
        .wlock_go  (wlock_go),
        .clr_go    (clr_go),
        .go_sector (go_sector),
        .go_lock   (go_lock),
        .err_set   (err_set),
        .wel       (wel),
        .err       (err),
        .lock_bits (lock_bits)
    );

    assign flag_status = {erase_suspend, err};

    // R1: state is clear in the first cycle after reset release
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wel && lock_bits == '0));

endmodule

// File: tb/spi_reg_cmd_decoder_bench.sv
`timescale 1ns/1ps
module spi_reg_cmd_decoder_bench;

    localparam int ADDR = 24;
    localparam int NSEC = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n = 1'b1;
    logic            sck = 1'b0;
    logic [3:0]      dq = 4'h0;
    logic [1:0]      mode = 2'd0;
    logic            erase_suspend = 1'b0;
    logic [2:0]      err_set = 3'b000;
    logic            wel;
    logic [3:0]      flag_status;
    logic [2*NSEC-1:0] lock_bits;

    int n_checks = 0;
    int n_fail   = 0;

    logic [2*NSEC-1:0] exp_lock = '0;
    logic              exp_wel  = 1'b0;
    logic [2:0]        exp_err  = 3'b000;

    always #2.5 clk = ~clk;

    spi_reg_cmd_decoder #(.ADDR_BITS(ADDR), .NUM_SECTORS(NSEC)) u_spi_reg_cmd_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sck           (sck),
        .dq            (dq),
        .mode          (mode),
        .erase_suspend (erase_suspend),
        .err_set       (err_set),
        .wel           (wel),
        .flag_status   (flag_status),
        .lock_bits     (lock_bits)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "lock_bits", 64'(lock_bits), 64'(exp_lock));
        chk(req, "wel", 64'(wel), 64'(exp_wel));
        chk(req, "flag_status", 64'(flag_status), 64'({erase_suspend, exp_err}));
    endtask

    // shifts nclk clocks of the MSB-aligned vector v in lane mode m
    task automatic send(input logic [1:0] m, input logic [63:0] v, input int nclk);
        int lanes;
        lanes = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
        mode = m;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            for (int j = 0; j < lanes; j++) begin
                int k;
                k = i * lanes + j;
                dq[lanes-1-j] = (k < 64) ? v[63-k] : 1'b0;
            end
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b0;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [63:0] lock_frame(input logic [ADDR-1:0] a, input logic [7:0] d);
        return {8'hE5, a, d, 24'h0};
    endfunction

    task automatic do_wren(input logic [1:0] m);
        int n;
        n = (m == 2'd1) ? 4 : (m == 2'd2) ? 2 : 8;
        send(m, {8'h06, 56'h0}, n);
        exp_wel = 1'b1;
    endtask

    task automatic t_reset;
        chk_all("R1");
    endtask

    task automatic t_wren;
        do_wren(2'd0);
        chk_all("R2");
    endtask

    task automatic t_lock_ext;
        do_wren(2'd0);
        send(2'd0, lock_frame(24'h5ABCDE, 8'hFE), 40);
        exp_lock[11:10] = 2'b10;
        exp_wel = 1'b0;
        chk_all("R3");
        chk("R5", "wel after lock", 64'(wel), 64'd0);
    endtask

    task automatic t_lock_lanes;
        do_wren(2'd1);
        chk("R4", "dual wel", 64'(wel), 64'd1);
        send(2'd1, lock_frame(24'hA00000, 8'h03), 20);
        exp_lock[21:20] = 2'b11;
        exp_wel = 1'b0;
        chk_all("R4");
        do_wren(2'd2);
        send(2'd2, lock_frame(24'hF12345, 8'h01), 10);
        exp_lock[31:30] = 2'b01;
        exp_wel = 1'b0;
        chk_all("R4");
    endtask

    task automatic t_no_wel;
        send(2'd0, lock_frame(24'h200000, 8'h03), 40);
        chk_all("R6");
    endtask

    task automatic t_bad_len;
        do_wren(2'd0);
        send(2'd0, lock_frame(24'h300000, 8'h02), 39);
        chk_all("R7");
        send(2'd0, lock_frame(24'h300000, 8'h02), 41);
        chk_all("R7");
        send(2'd2, lock_frame(24'h300000, 8'h02), 11);
        chk_all("R7");
        send(2'd0, lock_frame(24'h300000, 8'h02), 40);
        exp_lock[7:6] = 2'b10;
        exp_wel = 1'b0;
        chk_all("R7");
    endtask

    task automatic t_suspend;
        erase_suspend = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "suspend flag", 64'(flag_status[3]), 64'd1);
        do_wren(2'd0);
        send(2'd0, lock_frame(24'h7FFFFF, 8'h02), 40);
        exp_lock[15:14] = 2'b10;
        exp_wel = 1'b0;
        chk_all("R8");
        erase_suspend = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "suspend released", 64'(flag_status[3]), 64'd0);
    endtask

    task automatic t_flags;
        err_set = 3'b111;
        @(negedge clk);
        err_set = 3'b000;
        @(negedge clk);
        exp_err = 3'b111;
        chk_all("R10");
        do_wren(2'd0);
        send(2'd0, lock_frame(24'h100000, 8'h01), 40);
        exp_lock[3:2] = 2'b01;
        exp_wel = 1'b0;
        chk_all("R5");
        send(2'd0, {8'h50, 56'h0}, 7);
        chk_all("R9");
        send(2'd0, {8'h50, 56'h0}, 8);
        exp_err = 3'b000;
        chk_all("R9");
        err_set = 3'b010;
        @(negedge clk);
        err_set = 3'b000;
        @(negedge clk);
        exp_err = 3'b010;
        chk_all("R10");
        send(2'd2, {8'h50, 56'h0}, 13);
        exp_err = 3'b000;
        chk_all("R9");
    endtask

    task automatic t_unknown;
        do_wren(2'd0);
        send(2'd0, {8'hAB, 56'h0}, 8);
        chk_all("R11");
        send(2'd1, {8'hE4, 24'h400000, 8'h03, 24'h0}, 20);
        chk_all("R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_wren();
        t_lock_ext();
        t_lock_lanes();
        t_no_wel();
        t_bad_len();
        t_suspend();
        t_flags();
        t_unknown();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule